// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block models the feedback divider of a frequency synthesizer. A dual-modulus prescaler divides the input clock by either M+1 or M. A programmable main counter counts prescaler periods, and a swallow counter chooses how many of those periods use the longer modulus. A complete divide cycle is therefore M·N + A input clocks long. At the end of each cycle the block emits a pulse one input clock wide.

The base modulus M is picked with a two-bit selector: 16, 32, 64 or 128, which is 16 shifted left by the selector value. The low pair suits a lower-frequency loop and the high pair a higher-frequency loop. The N, A and modulus inputs are sampled only at a cycle boundary, so software or a sequencer may change them at any time without corrupting a count that is in progress. Values outside the legal range are clamped so that the ratio formula always holds.

Top module: `pulse_swallow_divider`

## Requirements
- R1: In steady state, consecutive output pulses are exactly M·N + A input clocks apart, where M = 16 << mod_sel (mod_sel 0→16, 1→32, 2→64, 3→128).
- R2: Each output pulse is high for exactly one input clock.
- R3: While rst_n is low, div_out is low. The first pulse after rst_n rises comes M·N + A clocks after release, using the input values present during reset.
- R4: With A = 0, the period is M·N, and the prescaler divides by M for the whole cycle.
- R5: An N value below 5 is treated as 5.
- R6: An A value not strictly less than the effective N is treated as effective N − 1.
- R7: N, A and mod_sel are sampled only at the clock of an output pulse. A change made within a cycle leaves that cycle's length unchanged and takes effect in the following cycle.
- R8: Within a cycle, the first A prescaler periods last M+1 clocks and the remaining N − A last M clocks. At every moment the remaining swallow count is below the remaining main count.
- R9: The full ranges work: N = 2047 with A = 127 gives a period of 16·2047 + 127 at mod_sel 0, and mod_sel 2 and 3 give the 64- and 128-based ratios.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset; loads the counters from the inputs |
| n_val | input | 11 | Main counter ratio N (legal 5..2047) |
| a_val | input | 7 | Swallow counter ratio A (legal 0..127, below N) |
| mod_sel | input | 2 | Prescaler base modulus select, M = 16 << mod_sel |
| div_out | output | 1 | One-clock pulse at the end of each divide cycle |

## Verification
On every cycle, the in-line assertions check the following: the pulse lasts one clock; the active modulus is held between boundaries; the prescaler count stays within the active modulus; the main count never falls to zero before a reload; the swallow count stays below the main count; and once the swallow count is spent, every following prescaler period restarts at M. Only the bench's scenarios can show the cycle length itself. The bench sweeps every legal A for small N at two moduli, covers the clamping of N and A, checks the wide extremes, and checks the deferral of a mid-cycle change. It does this by counting clocks between pulses against M·N + A computed independently.

// File: rtl/ps_div_pkg.sv
// Package ps_div_pkg
// Shared constants, types and the modulus decode for the pulse-swallow
// divider. Assumes the base modulus doubles with each selector step.
package ps_div_pkg;
    localparam int BASE_LOG2 = 4;                                   // smallest modulus is 16
    localparam int SEL_W     = 2;                                   // four modulus settings
    localparam int MAX_MOD   = 1 << (BASE_LOG2 + (1 << SEL_W) - 1); // 128
    localparam int PC_W      = $clog2(MAX_MOD + 1);                 // holds 0..MAX_MOD

    typedef logic [SEL_W-1:0] mod_sel_t;
    typedef logic [PC_W-1:0]  pc_t;

    // Base modulus M for a selector value.
    function automatic pc_t base_modulus(input mod_sel_t sel);
        return pc_t'(1 << (BASE_LOG2 + int'(sel)));
    endfunction
endpackage

// File: rtl/ps_range_guard.sv
// Module ps_range_guard
// Combinational clamp of the requested ratios. Raises N to the minimum
// and pulls A below the effective N, so that M*N+A always holds.
// Assumes N_W >= A_W and N_MIN >= 2.
module ps_range_guard #(
    parameter int N_W   = 11,
    parameter int A_W   = 7,
    parameter int N_MIN = 5
) (
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    output logic [N_W-1:0] n_eff,
    output logic [A_W-1:0] a_eff
);
    localparam int PAD_W = N_W - A_W;

    logic [N_W-1:0] a_wide;

    // Clamp N to the minimum, then clamp A to N-1.
    always_comb begin
        a_wide = {{PAD_W{1'b0}}, a_in};
        n_eff  = (n_in < N_W'(N_MIN)) ? N_W'(N_MIN) : n_in;
        if (a_wide >= n_eff) begin
            a_eff = A_W'(n_eff - 1'b1);
        end else begin
            a_eff = a_in;
        end
    end
endmodule

// File: rtl/ps_prescaler.sv
// Module ps_prescaler
// Dual-modulus prescaler model. It counts input clocks down to zero and
// flags a tick there. The next period lasts M+1 clocks when plus_next is
// high, and M clocks otherwise. Reset and load restart it with the new
// cycle's modulus. Assumes the modulus is at least 2.
module ps_prescaler
    import ps_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,       // cycle boundary
    input  logic load_plus1, // first period of the new cycle is M+1
    input  pc_t  load_mod,   // modulus for the new cycle
    input  pc_t  hold_mod,   // modulus of the running cycle
    input  logic plus_next,  // next period is M+1
    output pc_t  pc_cnt,
    output logic tick
);
    assign tick = (pc_cnt == '0);

    // Count down; restart with M or M-1 at each tick or reload.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            pc_cnt <= load_plus1 ? load_mod : pc_t'(load_mod - 1'b1);
        end else if (tick) begin
            pc_cnt <= plus_next ? hold_mod : pc_t'(hold_mod - 1'b1);
        end else begin
            pc_cnt <= pc_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ps_swallow_counter.sv
// Module ps_swallow_counter
// Swallow counter. It holds the number of prescaler periods still to be
// run at M+1, and steps down on each prescaler tick until it reaches zero.
module ps_swallow_counter #(
    parameter int A_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W-1:0] a_load,
    input  logic           tick,
    output logic [A_W-1:0] sc_cnt,
    output logic           plus_next
);
    // After this tick, another swallowed period remains.
    assign plus_next = (sc_cnt > A_W'(1));

    // Load A at the boundary, decrement on ticks while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            sc_cnt <= a_load;
        end else if (tick && (sc_cnt != '0)) begin
            sc_cnt <= sc_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ps_main_counter.sv
// Module ps_main_counter
// Main programmable counter. It counts prescaler ticks down from N and
// flags the last tick of the cycle. Assumes N >= 1 at every load.
module ps_main_counter #(
    parameter int N_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [N_W-1:0] n_load,
    input  logic           tick,
    output logic [N_W-1:0] nc_cnt,
    output logic           last
);
    assign last = tick && (nc_cnt == N_W'(1));

    // Load N at the boundary, decrement on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            nc_cnt <= n_load;
        end else if (tick) begin
            nc_cnt <= nc_cnt - 1'b1;
        end
    end

    // The count is reloaded before it can reach zero.
    AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        nc_cnt != '0); // R8
endmodule

// File: rtl/pulse_swallow_divider.sv
// Module pulse_swallow_divider
// Top of the pulse-swallow divider: prescaler, swallow counter, main
// counter and range guard. It emits a one-clock pulse every M*N+A input
// clocks, and samples N, A and the modulus select only at cycle boundaries.
// Assumes a synchronous active-low reset held for at least one clock.
module pulse_swallow_divider
    import ps_div_pkg::*;
#(
    parameter int N_W   = 11,
    parameter int A_W   = 7,
    parameter int N_MIN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_W-1:0]   n_val,
    input  logic [A_W-1:0]   a_val,
    input  logic [SEL_W-1:0] mod_sel,
    output logic             div_out
);
    logic [N_W-1:0] n_eff;
    logic [A_W-1:0] a_eff;
    logic [N_W-1:0] nc_cnt;
    logic [A_W-1:0] sc_cnt;
    mod_sel_t       act_sel;
    pc_t            pc_cnt;
    pc_t            hold_mod;
    pc_t            load_mod;
    logic           tick;
    logic           plus_next;
    logic           last;

    assign hold_mod = base_modulus(act_sel);
    assign load_mod = base_modulus(mod_sel);

    ps_range_guard #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) i_guard (
        .n_in  (n_val),
        .a_in  (a_val),
        .n_eff (n_eff),
        .a_eff (a_eff)
    );

    ps_prescaler i_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (last),
        .load_plus1 (a_eff != '0),
        .load_mod   (load_mod),
        .hold_mod   (hold_mod),
        .plus_next  (plus_next),
        .pc_cnt     (pc_cnt),
        .tick       (tick)
    );

    ps_swallow_counter #(.A_W(A_W)) i_swallow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (last),
        .a_load    (a_eff),
        .tick      (tick),
        .sc_cnt    (sc_cnt),
        .plus_next (plus_next)
    );

    ps_main_counter #(.N_W(N_W)) i_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (last),
        .n_load (n_eff),
        .tick   (tick),
        .nc_cnt (nc_cnt),
        .last   (last)
    );

    // Capture the modulus select for the cycle that starts now.
    always_ff @(posedge clk) begin
        if (!rst_n || last) begin
            act_sel <= mod_sel;
        end
    end

    // Register the end-of-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_out <= 1'b0;
        end else begin
            div_out <= last;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out); // R2
    AST_MOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(act_sel)); // R7
    AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pc_cnt <= hold_mod); // R1
    AST_SWALLOW_BELOW_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        {{(N_W-A_W){1'b0}}, sc_cnt} < nc_cnt); // R6
    AST_PLAIN_AFTER_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !last && sc_cnt <= A_W'(1)) |=> (pc_cnt == pc_t'(hold_mod - 1'b1))); // R8
endmodule

// File: tb/test_pulse_swallow_divider.sv
// Bench for pulse_swallow_divider: sweeps N and A at small moduli, covers
// the clamps, the extremes and deferred updates, and counts clocks between
// pulses against M*N+A.
module test_pulse_swallow_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] n_val = 11'd5;
    logic [6:0]  a_val = 7'd0;
    logic [1:0]  mod_sel = 2'd0;
    logic        div_out;

    int checks = 0;
    int fails = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk;

    pulse_swallow_divider i_pulse_swallow_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .n_val   (n_val),
        .a_val   (a_val),
        .mod_sel (mod_sel),
        .div_out (div_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!div_out && !timed_out);
    endtask

    task automatic measure(output int p);
        int c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (!div_out && !timed_out);
        p = c;
    endtask

    // Apply values, let the running cycle end, then time one full cycle.
    task automatic run_ratio(input int sel, input int n, input int a, input int exp, input string tag);
        int p;
        mod_sel = 2'(sel);
        n_val = 11'(n);
        a_val = 7'(a);
        wait_pulse();
        measure(p);
        check(tag, p, exp);
    endtask

    task automatic run_all();
        int p;
        int c;
        // R3: reset holds the output low, then first pulse after M*N+A clocks
        repeat (3) @(negedge clk);
        check("R3 reset low", int'(div_out), 0);
        rst_n = 1'b1;
        measure(p);
        check("R3 first pulse", p, 16 * 5);
        @(negedge clk);
        check("R2 pulse width", int'(div_out), 0);

        // R1 R8 R4: all A for small N at M=16
        for (int n = 5; n <= 12; n++) begin
            for (int a = 0; a < n; a++) begin
                run_ratio(0, n, a, 16 * n + a, a == 0 ? "R4 ratio" : "R1 R8 ratio");
            end
        end
        // R1 R8: all A for small N at M=32
        for (int n = 5; n <= 8; n++) begin
            for (int a = 0; a < n; a++) begin
                run_ratio(1, n, a, 32 * n + a, "R1 R8 ratio m32");
            end
        end
        @(negedge clk);
        check("R2 pulse width after sweep", int'(div_out), 0);

        // R5: N below the minimum
        run_ratio(0, 0, 0, 16 * 5, "R5 n zero");
        run_ratio(0, 3, 2, 16 * 5 + 2, "R5 n three");
        // R6: A not below N
        run_ratio(0, 7, 100, 16 * 7 + 6, "R6 a large");
        run_ratio(0, 9, 9, 16 * 9 + 8, "R6 a equal");
        run_ratio(0, 2, 9, 16 * 5 + 4, "R5 R6 both");

        // R9: wide moduli and extremes
        run_ratio(2, 6, 5, 64 * 6 + 5, "R9 m64");
        run_ratio(3, 5, 4, 128 * 5 + 4, "R9 m128");
        run_ratio(3, 20, 0, 128 * 20, "R9 R4 m128 a0");
        run_ratio(0, 128, 127, 16 * 128 + 127, "R9 a max");
        run_ratio(0, 2047, 127, 16 * 2047 + 127, "R9 n max");

        // R7: change within a cycle, old cycle length kept
        run_ratio(0, 6, 2, 16 * 6 + 2, "R7 setup");
        c = 0;
        do begin
            @(negedge clk);
            c++;
            if (c == 20) begin
                mod_sel = 2'd1;
                n_val = 11'd7;
                a_val = 7'd3;
            end
        end while (!div_out && !timed_out);
        check("R7 current cycle kept", c, 16 * 6 + 2);
        measure(p);
        check("R7 new values next cycle", p, 32 * 7 + 3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                timed_out = 1'b1;
                checks++;
                fails++;
                $display("FAIL watchdog R1: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule